// File: doc/BRIEF.md
# Serial Port Ready-Flag Logic

This block keeps the four ready flags of a two-channel character serial subsystem: a keyboard channel and a printer channel, each with a receive-ready flag and a transmit-ready flag. It sits on a 12-bit programmed-I/O bus. Each I/O cycle carries a 9-bit device/function code that the block decodes. The block sets and clears its flags on command and reports a skip indication when a test-and-clear code finds its flag set. For the character transfer codes it returns fixed C0/C1 control-line responses, read and write strobes for the serial channels, and the low 8 bits of the bus data for transmission.

The serial channels raise a data-available line and a transmit-empty line. The block sets a flag only on a rising edge of the matching line, so a line that stays high after software has cleared the flag does not set it again. An active-low I/O clear input drops all four flags at once.

Top module: `uart_flag_iot`

## Requirements
- R1: After reset all four flags are clear, so no test-and-clear code reports skip until a flag has been set.
- R2: With `iot_valid_i` high, code 110 sets the keyboard receive flag, 050 the keyboard transmit flag, 320 the printer receive flag and 330 the printer transmit flag (all codes octal). The flag is set from the next cycle on.
- R3: Codes 111, 051, 321 and 331 test and clear the matching flag. `skip_o` is high in that same cycle exactly when the flag was set, and the flag is clear from the next cycle on.
- R4: A low-to-high transition of `kbd_rx_avail_i`, `kbd_tx_empty_i`, `prt_rx_avail_i` or `prt_tx_empty_i` sets the matching flag in the next cycle. A line that stays high does not set the flag again after it has been cleared.
- R5: If a set code and a rising edge for the same flag arrive in one cycle, the flag ends up set. If a clear code and a rising edge arrive in one cycle, the flag also ends up set, while `skip_o` still reports the value the flag had before that cycle.
- R6: While `ioclr_ni` is low, all four flags are cleared at each clock edge. This takes priority over set codes and rising edges.
- R7: During a valid cycle, `c0_o` alone is high for codes 056, 112, 322 and 336, `c1_o` alone for 114 and 324, and both for 116 and 326. Both are low for every other code and whenever `iot_valid_i` is low.
- R8: `kbd_rx_rd_o` is high for valid codes 114 and 116, and `prt_rx_rd_o` for valid codes 324 and 326. Both are low otherwise.
- R9: `kbd_tx_wr_o` is high for valid codes 054 and 056, and `prt_tx_wr_o` for valid codes 334 and 336. During either strobe `tx_data_o` equals `iot_data_i[7:0]`, and it is zero otherwise.
- R10: `skip_o` is low for every code other than the four test-and-clear codes, and whenever `iot_valid_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ioclr_ni | input | 1 | Active-low I/O clear, drops all flags |
| iot_valid_i | input | 1 | An I/O cycle is present on the bus |
| iot_code_i | input | 9 | Device/function code of the I/O cycle |
| iot_data_i | input | 12 | Bus data word |
| kbd_rx_avail_i | input | 1 | Keyboard channel data-available line |
| kbd_tx_empty_i | input | 1 | Keyboard channel transmit-empty line |
| prt_rx_avail_i | input | 1 | Printer channel data-available line |
| prt_tx_empty_i | input | 1 | Printer channel transmit-empty line |
| skip_o | output | 1 | Skip response to a test-and-clear code |
| c0_o | output | 1 | C0 control-line response |
| c1_o | output | 1 | C1 control-line response |
| kbd_rx_rd_o | output | 1 | Read strobe for the keyboard receive character |
| kbd_tx_wr_o | output | 1 | Write strobe for the keyboard transmitter |
| prt_rx_rd_o | output | 1 | Read strobe for the printer receive character |
| prt_tx_wr_o | output | 1 | Write strobe for the printer transmitter |
| tx_data_o | output | 8 | Character to transmit, low bits of bus data |

## Verification
The assertions check on every cycle the relations that hold in any state. I/O clear empties the flags, a rising line sets its flag, a test-and-clear with no competing edge leaves the flag clear, skip and control responses occur only in valid cycles, at most one channel strobe is active, and transmit data stays zero outside a write. The bench's reference model alone can show the ordering outcomes. These are a set or clear that collides with an edge, the test-and-clear reporting the pre-cycle flag value, and a line held high after a clear leaving the flag down. It also runs a full sweep of all 512 codes against the response table.

// File: rtl/uart_flag_pkg.sv
package uart_flag_pkg;
  localparam int CODE_W = 9;
  localparam int NPORT  = 2;
  localparam int NFLAG  = 2 * NPORT;

  // flag order: kbd rx, kbd tx, prt rx, prt tx; clear code = set code | 1
  localparam logic [CODE_W-1:0] SET_CODE [NFLAG] = '{9'o110, 9'o050, 9'o320, 9'o330};
  // per port: keyboard, printer
  localparam logic [CODE_W-1:0] RX_BASE  [NPORT] = '{9'o114, 9'o324};
  localparam logic [CODE_W-1:0] TX_BASE  [NPORT] = '{9'o054, 9'o334};
  localparam logic [CODE_W-1:0] RX_AUX   [NPORT] = '{9'o112, 9'o322};

  typedef struct packed {
    logic c1;
    logic c0;
  } ctl_resp_t;
endpackage

// File: rtl/uart_flag_decode.sv
module uart_flag_decode
  import uart_flag_pkg::*;
(
  input  logic              valid_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [NFLAG-1:0]  set_o,
  output logic [NFLAG-1:0]  clr_o,
  output logic [NPORT-1:0]  rx_rd_o,
  output logic [NPORT-1:0]  tx_wr_o,
  output ctl_resp_t         ctl_o
);
  logic [NPORT-1:0] c0_p, c1_p;

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    assign set_o[i] = valid_i && (code_i == SET_CODE[i]);
    assign clr_o[i] = valid_i && (code_i == (SET_CODE[i] | 9'd1));
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic rx_a, rx_b, tx_a, tx_b, aux;
    assign rx_a = (code_i == RX_BASE[p]);
    assign rx_b = (code_i == RX_BASE[p] + 9'd2);
    assign tx_a = (code_i == TX_BASE[p]);
    assign tx_b = (code_i == TX_BASE[p] + 9'd2);
    assign aux  = (code_i == RX_AUX[p]);
    assign rx_rd_o[p] = valid_i && (rx_a || rx_b);
    assign tx_wr_o[p] = valid_i && (tx_a || tx_b);
    assign c0_p[p]    = valid_i && (rx_b || tx_b || aux);
    assign c1_p[p]    = valid_i && (rx_a || rx_b);
  end

  assign ctl_o.c0 = |c0_p;
  assign ctl_o.c1 = |c1_p;
endmodule

// File: rtl/uart_flag_cell.sv
module uart_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ioclr_ni,
  input  logic line_i,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic line_q;
  logic rise;

  assign rise = line_i && !line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      line_q <= line_i;
      if (!ioclr_ni)           flag_o <= 1'b0;
      else if (rise || set_i)  flag_o <= 1'b1;  // edge beats a clear code
      else if (clr_i)          flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_flag_iot.sv
module uart_flag_iot
  import uart_flag_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int CHAR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ioclr_ni,
  input  logic              iot_valid_i,
  input  logic [CODE_W-1:0] iot_code_i,
  input  logic [DATA_W-1:0] iot_data_i,
  input  logic              kbd_rx_avail_i,
  input  logic              kbd_tx_empty_i,
  input  logic              prt_rx_avail_i,
  input  logic              prt_tx_empty_i,
  output logic              skip_o,
  output logic              c0_o,
  output logic              c1_o,
  output logic              kbd_rx_rd_o,
  output logic              kbd_tx_wr_o,
  output logic              prt_rx_rd_o,
  output logic              prt_tx_wr_o,
  output logic [CHAR_W-1:0] tx_data_o
);
  logic [NFLAG-1:0] set_v, clr_v, line_v, flag_q;
  logic [NPORT-1:0] rx_rd, tx_wr;
  ctl_resp_t        ctl;
  logic             unused_data_hi;

  assign line_v = {prt_tx_empty_i, prt_rx_avail_i, kbd_tx_empty_i, kbd_rx_avail_i};

  uart_flag_decode u_dec (
    .valid_i (iot_valid_i),
    .code_i  (iot_code_i),
    .set_o   (set_v),
    .clr_o   (clr_v),
    .rx_rd_o (rx_rd),
    .tx_wr_o (tx_wr),
    .ctl_o   (ctl)
  );

  for (genvar i = 0; i < NFLAG; i++) begin : g_cell
    uart_flag_cell u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ioclr_ni (ioclr_ni),
      .line_i   (line_v[i]),
      .set_i    (set_v[i]),
      .clr_i    (clr_v[i]),
      .flag_o   (flag_q[i])
    );
  end

  assign skip_o      = |(clr_v & flag_q);
  assign c0_o        = ctl.c0;
  assign c1_o        = ctl.c1;
  assign kbd_rx_rd_o = rx_rd[0];
  assign prt_rx_rd_o = rx_rd[1];
  assign kbd_tx_wr_o = tx_wr[0];
  assign prt_tx_wr_o = tx_wr[1];
  assign tx_data_o   = (|tx_wr) ? iot_data_i[CHAR_W-1:0] : '0;
  assign unused_data_hi = ^iot_data_i[DATA_W-1:CHAR_W];
endmodule

// File: rtl/uart_flag_iot_chk.sv
module uart_flag_iot_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ioclr_ni,
  input logic       iot_valid_i,
  input logic [8:0] iot_code_i,
  input logic       kbd_rx_avail_i,
  input logic       kbd_tx_empty_i,
  input logic [3:0] flag_q,
  input logic       skip_o,
  input logic       c0_o,
  input logic       c1_o,
  input logic       kbd_rx_rd_o,
  input logic       kbd_tx_wr_o,
  input logic       prt_rx_rd_o,
  input logic       prt_tx_wr_o,
  input logic [7:0] tx_data_o
);
  // R6
  ioclr_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ioclr_ni |=> (flag_q == 4'b0));
  // R4
  rise_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ioclr_ni && $rose(kbd_rx_avail_i)) |=> flag_q[0]);
  // R3
  clr_kbd_tx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iot_valid_i && iot_code_i == 9'o051 && !kbd_tx_empty_i) |=> !flag_q[1]);
  // R10
  skip_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_o |-> (iot_valid_i && flag_q != 4'b0));
  // R7
  ctl_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c0_o || c1_o) |-> iot_valid_i);
  // R8
  strobe_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({kbd_rx_rd_o, kbd_tx_wr_o, prt_rx_rd_o, prt_tx_wr_o}));
  // R9
  tx_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(kbd_tx_wr_o || prt_tx_wr_o) |-> (tx_data_o == 8'h00));
endmodule

bind uart_flag_iot uart_flag_iot_chk u_chk (.*);

// File: tb/uart_flag_iot_bench.sv
module uart_flag_iot_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr_n = 1'b1;
  logic       v = 1'b0;
  logic [8:0] code = '0;
  logic [11:0] data = '0;
  logic [3:0] lines = '0;  // {prt tx, prt rx, kbd tx, kbd rx}

  logic       skip, c0, c1, krd, kwr, prd, pwr;
  logic [7:0] txd;

  int compared = 0, mismatched = 0;
  bit done = 0;
  bit m_flag [4];
  bit m_prev [4];

  always #10 clk = ~clk;

  uart_flag_iot u_uart_flag_iot (
    .clk_i(clk), .rst_ni(rst_n), .ioclr_ni(clr_n), .iot_valid_i(v),
    .iot_code_i(code), .iot_data_i(data),
    .kbd_rx_avail_i(lines[0]), .kbd_tx_empty_i(lines[1]),
    .prt_rx_avail_i(lines[2]), .prt_tx_empty_i(lines[3]),
    .skip_o(skip), .c0_o(c0), .c1_o(c1),
    .kbd_rx_rd_o(krd), .kbd_tx_wr_o(kwr), .prt_rx_rd_o(prd), .prt_tx_wr_o(pwr),
    .tx_data_o(txd)
  );

  function automatic int set_idx(input logic [8:0] c);
    case (c)
      9'o110: return 0;  9'o050: return 1;
      9'o320: return 2;  9'o330: return 3;
      default: return -1;
    endcase
  endfunction

  function automatic int clr_idx(input logic [8:0] c);
    case (c)
      9'o111: return 0;  9'o051: return 1;
      9'o321: return 2;  9'o331: return 3;
      default: return -1;
    endcase
  endfunction

  function automatic logic [1:0] exp_ctl(input logic [8:0] c);  // {c1,c0}
    case (c)
      9'o056, 9'o112, 9'o322, 9'o336: return 2'b01;
      9'o114, 9'o324:                 return 2'b10;
      9'o116, 9'o326:                 return 2'b11;
      default:                        return 2'b00;
    endcase
  endfunction

  task automatic chk(input logic act, input logic exp, input string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0b expected %0b (code %o)", tag, act, exp, code);
    end
  endtask

  // inputs already driven at the falling edge; compare, then advance one clock
  task automatic step(input int want_skip, input string tag);
    logic e_skip, e_krd, e_kwr, e_prd, e_pwr;
    logic [1:0] e_ctl;
    logic [7:0] e_txd;
    int ci;
    #2;
    ci     = clr_idx(code);
    e_skip = v && ci >= 0 && m_flag[ci];
    e_ctl  = v ? exp_ctl(code) : 2'b00;
    e_krd  = v && (code == 9'o114 || code == 9'o116);
    e_prd  = v && (code == 9'o324 || code == 9'o326);
    e_kwr  = v && (code == 9'o054 || code == 9'o056);
    e_pwr  = v && (code == 9'o334 || code == 9'o336);
    e_txd  = (e_kwr || e_pwr) ? data[7:0] : 8'h00;
    chk(skip, e_skip, "R3/R10 skip");
    chk(c0, e_ctl[0], "R7 c0");
    chk(c1, e_ctl[1], "R7 c1");
    chk(krd, e_krd, "R8 kbd rd");
    chk(prd, e_prd, "R8 prt rd");
    chk(kwr, e_kwr, "R9 kbd wr");
    chk(pwr, e_pwr, "R9 prt wr");
    compared++;
    if (txd !== e_txd) begin
      mismatched++;
      $display("FAIL R9 tx data: actual %h expected %h", txd, e_txd);
    end
    if (want_skip >= 0) chk(skip, want_skip[0], tag);
    @(posedge clk);
    for (int i = 0; i < 4; i++) begin
      bit rise = lines[i] && !m_prev[i];
      if (!clr_n)                           m_flag[i] = 0;
      else if (rise || (v && set_idx(code) == i)) m_flag[i] = 1;
      else if (v && clr_idx(code) == i)     m_flag[i] = 0;
      m_prev[i] = lines[i];
    end
    @(negedge clk);
    v = 1'b0; clr_n = 1'b1;
  endtask

  task automatic op(input logic [8:0] c, input int want, input string tag);
    v = 1'b1; code = c;
    step(want, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL R1 watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [8:0] clrs [4] = '{9'o111, 9'o051, 9'o321, 9'o331};
    logic [8:0] sets [4] = '{9'o110, 9'o050, 9'o320, 9'o330};
    for (int i = 0; i < 4; i++) begin m_flag[i] = 0; m_prev[i] = 0; end
    repeat (2) @(negedge clk);
    // R1: outputs quiet in reset
    #2;
    chk(skip, 1'b0, "R1 reset skip");
    chk(c0 | c1, 1'b0, "R1 reset ctl");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 4; i++) op(clrs[i], 0, "R1 no flag after reset");

    // R2 / R3: set then test-and-clear twice
    for (int i = 0; i < 4; i++) begin
      op(sets[i], 0, "R2 set no skip");
      op(clrs[i], 1, "R2/R3 skip when set");
      op(clrs[i], 0, "R3 cleared");
    end

    // R4: rising edge sets, held level does not re-set
    lines = 4'b0101; step(-1, "");
    op(9'o111, 1, "R4 kbd rx edge");
    op(9'o321, 1, "R4 prt rx edge");
    op(9'o111, 0, "R4 held high no re-set");
    op(9'o321, 0, "R4 held high no re-set");
    lines = 4'b0000; step(-1, "");

    // R5: set + edge, clear + edge
    lines = 4'b0010; op(9'o050, 0, "R5 set with edge");
    op(9'o051, 1, "R5 set+edge gives set");
    lines = 4'b0000; step(-1, "");
    lines = 4'b1000; op(9'o331, 0, "R5 clear with edge reports old");
    op(9'o331, 1, "R5 edge beats clear");
    lines = 4'b0000; step(-1, "");

    // R6: io clear drops all, beats edge and set
    for (int i = 0; i < 4; i++) op(sets[i], -1, "");
    clr_n = 1'b0; lines = 4'b0001; v = 1'b1; code = 9'o050; step(-1, "");
    for (int i = 0; i < 4; i++) op(clrs[i], 0, "R6 io clear");
    lines = 4'b0000; step(-1, "");

    // R7..R10: full code sweep, valid and not valid
    for (int c = 0; c < 512; c++) begin
      v = 1'b1; code = c[8:0]; data = 12'(c * 37 + 5);
      step(-1, "");
      v = 1'b0; code = c[8:0];
      step(-1, "");
    end

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom_range(0, 15);
      v     = ($urandom_range(0, 3) != 0);
      code  = (r < 8) ? ((r < 4) ? sets[r] : clrs[r-4]) : 9'($urandom_range(0, 511));
      data  = 12'($urandom);
      lines = 4'($urandom);
      clr_n = ($urandom_range(0, 31) != 0);
      step(-1, "");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule